// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This unit applies one integer or bitwise operation across a 128-bit word that is split into lanes of 8, 16 or 32 bits. It provides lane-wise wrapping add and subtract, lane equality and lane bit-test, a bitwise merge that draws its mask from the current destination value, and a full-width complement. The compare and test operations produce a mask per lane: all ones when the condition is true, all zeros when it is false. Mask results like these can be fed directly into the merge operation.

A caller presents two operands, the present destination value, a size code and an operation code, and raises the valid strobe for one cycle. One clock edge later the unit presents the registered result with a valid flag. A reserved size code, or an unused operation code, gives a zero result and raises a flag that marks the request as illegal. The result register keeps its value until the next strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: The size code `size` partitions the word as follows: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes and 2 gives four 32-bit lanes. Lane k occupies bits starting at k times the lane width.
- R2: Operation code 0 (add) sums each lane of `opa` and `opb` modulo 2^width. No carry passes into the next lane.
- R3: Operation code 1 (subtract) gives `opa` minus `opb` in each lane, modulo 2^width. No borrow passes into the next lane.
- R4: Operation code 2 (equal) sets a lane to all ones when the two operand lanes match, and to all zeros otherwise.
- R5: Operation code 3 (test) sets a lane to all ones when the bitwise AND of the two operand lanes is nonzero, and to all zeros otherwise.
- R6: Operation code 4 (select) computes every bit as (`dest` AND `opa`) OR (NOT `dest` AND `opb`), for size codes 0 to 2.
- R7: Operation code 5 (invert) returns the complement of all 128 bits of `opa`. The result is the same for size codes 0, 1 and 2.
- R8: When the size code is 3 or the operation code is 6 or 7, the result is zero and `illegal` is high for that result cycle. `illegal` is low in every other cycle.
- R9: `out_valid`, `result` and `illegal` are registered. They reflect the request that `in_valid` accepted at the previous rising edge. `result` holds its value in cycles that have no strobe. During reset all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Lane size code |
| opa | input | 128 | First operand |
| opb | input | 128 | Second operand |
| dest | input | 128 | Current destination value, used as the select mask |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |
| illegal | output | 1 | Reserved size or operation code seen |

## Verification
Every result, mask and illegal flag is due exactly one rising edge after the strobe that carries its request. The bench drives each request on a falling edge. On the next falling edge it compares the outputs with the expectation it stored for that request, and only then drives the following request. Idle cycles are mixed in. In those cycles the bench expects `out_valid` and `illegal` low and the previous result unchanged. Directed cases place all-ones lanes against one, and zero against one, at every size. This exposes any carry or borrow that leaks across a lane edge.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int NBYTES = 16,
  localparam int W = 8 * NBYTES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [1:0]   size,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] dest,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         illegal
);

  logic              sub;
  logic              bad;
  logic [NBYTES:0]   cy;
  logic [NBYTES-1:0] eqb, nzb, eql, nzl;
  logic [W-1:0]      sum, eqm, tsm, nxt;

  assign sub = (op == 3'd1);
  assign bad = (size == 2'd3) || (op > 3'd5);
  assign cy[0] = sub;

  genvar i;
  generate
    for (i = 0; i < NBYTES; i++) begin : g_byte
      localparam int B2 = i - (i % 2);
      localparam int B4 = i - (i % 4);
      logic [7:0] a8, b8, bx;
      logic [8:0] s9;
      logic       first, cin;
      assign a8 = opa[8*i +: 8];
      assign b8 = opb[8*i +: 8];
      assign bx = sub ? ~b8 : b8;
      assign first = (size == 2'd0) || (size == 2'd1 && (i % 2) == 0) ||
                     (size == 2'd2 && (i % 4) == 0);
      assign cin = first ? sub : cy[i];
      assign s9 = {1'b0, a8} + {1'b0, bx} + {8'd0, cin};
      assign cy[i+1] = s9[8];
      assign sum[8*i +: 8] = s9[7:0];
      assign eqb[i] = (a8 == b8);
      assign nzb[i] = |(a8 & b8);
      assign eql[i] = (size == 2'd0) ? eqb[i] :
                      (size == 2'd1) ? &eqb[B2 +: 2] : &eqb[B4 +: 4];
      assign nzl[i] = (size == 2'd0) ? nzb[i] :
                      (size == 2'd1) ? |nzb[B2 +: 2] : |nzb[B4 +: 4];
      assign eqm[8*i +: 8] = {8{eql[i]}};
      assign tsm[8*i +: 8] = {8{nzl[i]}};
    end
  endgenerate

  always_comb begin
    case (op)
      3'd0, 3'd1: nxt = sum;
      3'd2:       nxt = eqm;
      3'd3:       nxt = tsm;
      3'd4:       nxt = (dest & opa) | (~dest & opb);
      3'd5:       nxt = ~opa;
      default:    nxt = '0;
    endcase
    if (bad) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && bad;
      if (in_valid) result <= nxt;
    end
  end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [1:0]   size,
  input logic [127:0] opa,
  input logic [127:0] opb,
  input logic [127:0] dest,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         illegal
);

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (out_valid && result == '0));

  // R8
  reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd3) |=> illegal);

  // R7
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5 && size != 2'd3) |=> result == ~$past(opa));

  // R6
  select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && size != 2'd3) |=>
      result == (($past(dest) & $past(opa)) | (~$past(dest) & $past(opb))));

endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (.*);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   size = '0;
  logic [127:0] opa = '0, opb = '0, dest = '0;
  logic         out_valid, illegal;
  logic [127:0] result;

  int vectors = 0, fails = 0;
  logic         e_valid = 1'b0, e_ill = 1'b0;
  logic [127:0] e_res = '0;
  string        e_tag = "R9";
  bit           done = 0;

  always #(PERIOD/2) clk = ~clk;

  simd_lane_alu u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .size(size), .opa(opa), .opb(opb), .dest(dest), .out_valid(out_valid),
    .result(result), .illegal(illegal));

  function automatic logic [128:0] model(input logic [2:0] o, input logic [1:0] s,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] d);
    logic [127:0] r = '0;
    int w;
    if (s == 2'd3 || o > 3'd5) return {1'b1, 128'd0};
    if (o == 3'd4) return {1'b0, (d & a) | (~d & b)};
    if (o == 3'd5) return {1'b0, ~a};
    w = 8 << s;
    for (int l = 0; l < 128 / w; l++) begin
      logic [31:0] la, lb, lr, m;
      m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      la = 32'(a >> (l * w)) & m;
      lb = 32'(b >> (l * w)) & m;
      case (o)
        3'd0:    lr = la + lb;
        3'd1:    lr = la - lb;
        3'd2:    lr = (la == lb) ? m : 32'd0;
        default: lr = ((la & lb) != 0) ? m : 32'd0;
      endcase
      r = r | (128'(lr & m) << (l * w));
    end
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic [1:0] s);
    if (s == 2'd3 || o > 3'd5) return "R8";
    case (o)
      3'd0: return "R1,R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_out();
    vectors++;
    if (out_valid !== e_valid || result !== e_res || illegal !== e_ill) begin
      fails++;
      $display("FAIL %s: got v=%b ill=%b res=%h exp v=%b ill=%b res=%h",
        e_tag, out_valid, illegal, result, e_valid, e_ill, e_res);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] o, input logic [1:0] s,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] d);
    logic [128:0] m;
    @(negedge clk);
    check_out();
    in_valid = v; op = o; size = s; opa = a; opb = b; dest = d;
    e_valid = v;
    if (v) begin
      m = model(o, s, a, b, d);
      e_res = m[127:0];
      e_ill = m[128];
      e_tag = tag_of(o, s);
    end else begin
      e_ill = 1'b0;
      e_tag = "R9";
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] ones = '1;
    logic [127:0] one8 = {16{8'h01}}, one16 = {8{16'h0001}}, one32 = {4{32'h1}};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(); // R9 reset state
    rst_n = 1'b1;
    // directed lane-boundary cases
    apply(1, 3'd0, 2'd0, ones, one8, '0);
    apply(1, 3'd0, 2'd1, ones, one16, '0);
    apply(1, 3'd0, 2'd2, ones, one32, '0);
    apply(1, 3'd1, 2'd0, '0, one8, '0);
    apply(1, 3'd1, 2'd1, '0, one16, '0);
    apply(1, 3'd1, 2'd2, '0, one32, '0);
    apply(1, 3'd2, 2'd1, 128'h00ff_1234, 128'h0000_1234, '0);
    apply(1, 3'd3, 2'd2, 128'h8000_0000_0000_0001, 128'h8000_0000_0000_0002, '0);
    apply(1, 3'd4, 2'd0, rnd128(), rnd128(), 128'hffff_0000_f0f0);
    apply(0, 3'd0, 2'd0, '0, '0, '0);
    apply(1, 3'd5, 2'd0, 128'h1234_5678, '0, '0);
    apply(1, 3'd5, 2'd2, 128'h1234_5678, '0, '0);
    apply(1, 3'd5, 2'd3, 128'h1234_5678, '0, '0);
    apply(1, 3'd6, 2'd0, ones, ones, ones);
    apply(1, 3'd7, 2'd1, ones, ones, ones);
    apply(0, 3'd0, 2'd0, '0, '0, '0);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [127:0] a, b;
      logic [2:0] o;
      logic [1:0] s;
      a = rnd128();
      b = rnd128();
      o = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(6, 7)) : 3'($urandom_range(0, 5));
      s = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      if (o == 3'd2 || o == 3'd3) b = a ^ (rnd128() & rnd128() & rnd128() & rnd128());
      if (o == 3'd3 && $urandom_range(0, 1) == 1) b = ~a & rnd128();
      apply($urandom_range(0, 7) != 0, o, s, a, b, rnd128());
    end
    apply(0, 3'd0, 2'd0, '0, '0, '0);
    @(negedge clk);
    check_out();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule